// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps an 8-bit record of which kind of event last reset the system, and it produces the system reset itself. Four request inputs can cause a reset: the power-on detector, a watchdog overflow, a voltage supervisor trip and a low-level detector trip. An active-low external reset pin can also cause one. All of these are merged into a single system reset output. That output is held for a fixed number of cycles after the last request goes away.

The flag bits sit outside the system reset domain. System reset never clears them. A cause only ever sets its own bit. The flags return to 0 only when software writes the register. The usual sequence is: software writes zeros, and later reads the register to find which cause fired. The external pin triggers a reset but leaves no trace in the register. At power-on, only the power-on bit takes a defined value. The supervisor and low-level bits keep whatever state the flops come up with, which is modelled by the parameter `POWERUP_IMAGE`. Software reaches the register through a simple select, write-enable, write-data and read-data port.

Top module: `rstc_cause_reg`

## Requirements
- R1: The register image places the flags as follows: power-on at bit 0, watchdog at bit 2, supervisor at bit 3 and low-level detector at bit 4. Bits 1, 5, 6 and 7 always read 0, whatever was written.
- R2: `reg_rdata_o` shows the current flag image combinationally while `reg_sel_i` is 1, and is 0 while `reg_sel_i` is 0.
- R3: While `por_i` is 1, the power-on flag is set at every clock edge and `sys_rst_o` is 1.
- R4: Power-on leaves the watchdog, supervisor and low-level flags unchanged. Their start-up value is taken from `POWERUP_IMAGE`; they are not forced to 0.
- R5: A one-cycle pulse on `wdt_req_i`, `vls_req_i` or `lld_req_i` sets its flag at the same clock edge that raises `sys_rst_o`.
- R6: A cause sets only its own flag. Every other flag keeps its value.
- R7: The external pin `ext_rst_n_i` passes through a two-flop synchronizer. `sys_rst_o` rises at the third clock edge that samples the pin low. The pin never sets any flag.
- R8: `sys_rst_o` stays at 1 for 16 clock cycles after the last edge at which any reset source was seen. A single-cycle pulse therefore gives 17 cycles of reset. The pin held low for N sampled cycles gives N+16 cycles. Releasing power-on gives 16 further cycles.
- R9: A write (`reg_sel_i` and `reg_we_i` both 1) while `sys_rst_o` is 0 loads write-data bits 0, 2, 3 and 4 into the corresponding flags. Writing 0 to a flag clears it.
- R10: A write made while `sys_rst_o` is 1 has no effect on the flags.
- R11: If a cause pulse and a write land at the same edge, the flag of that cause ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset request, active high, held for several cycles |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous to the clock |
| wdt_req_i | input | 1 | Watchdog overflow reset request, one-cycle pulse |
| vls_req_i | input | 1 | Voltage supervisor reset request, one-cycle pulse |
| lld_req_i | input | 1 | Low-level detector reset request, one-cycle pulse |
| reg_sel_i | input | 1 | Register address match |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| sys_rst_o | output | 1 | Stretched system reset, active high |

## Verification
Each cause is pulsed on its own on top of a known flag state. This shows that it sets exactly its bit and leaves the other bits alone. It also shows the difference between a pulse that sets a flag and the pin, which sets nothing.

The reset length is measured for four stimuli:
- the power-on release (16 cycles);
- a single pulse (17 cycles);
- a five-cycle pin assertion (21 cycles), which also shows the two-cycle synchronizer delay by when the reset starts;
- a write issued inside a reset window, which must be ignored.

A write and a cause on the same edge show which of the two takes precedence. Writing all ones and then all zeros checks the bit layout and the reserved bits that read back as 0.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned N_CAUSE = 4;
  // flag index -> register bit position (0: power-on, 1: watchdog, 2: supervisor, 3: low level)
  localparam int unsigned CAUSE_BIT [N_CAUSE] = '{0, 2, 3, 4};

  function automatic logic [REG_W-1:0] flags_to_image(input logic [N_CAUSE-1:0] f);
    logic [REG_W-1:0] img;
    img = '0;
    for (int i = 0; i < N_CAUSE; i++) img[CAUSE_BIT[i]] = f[i];
    return img;
  endfunction

  function automatic logic [N_CAUSE-1:0] image_to_flags(input logic [REG_W-1:0] img);
    logic [N_CAUSE-1:0] f;
    for (int i = 0; i < N_CAUSE; i++) f[i] = img[CAUSE_BIT[i]];
    return f;
  endfunction

  function automatic logic [REG_W-1:0] live_mask();
    return flags_to_image({N_CAUSE{1'b1}});
  endfunction
endpackage

// File: rtl/rstc_pin_sync.sv
module rstc_pin_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q = {STAGES{RST_VAL}};

  always_ff @(posedge clk_i) begin
    if (rst_i) sh_q <= {STAGES{RST_VAL}};
    else       sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int unsigned N_SRC = 5,
  parameter int unsigned HOLD  = 16
) (
  input  logic             clk_i,
  input  logic [N_SRC-1:0] src_i,
  output logic             rst_o
);
  localparam int unsigned CNT_W = $clog2(HOLD + 1);

  logic [CNT_W-1:0] cnt_q = CNT_W'(HOLD);
  logic             rst_q = 1'b1;

  always_ff @(posedge clk_i) begin
    if (|src_i) begin
      cnt_q <= CNT_W'(HOLD);
      rst_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      rst_q <= 1'b1;
    end else begin
      rst_q <= 1'b0;
    end
  end

  assign rst_o = rst_q;

  // R8: any live source raises reset at the next edge
  a_r8_src_raises: assert property (@(posedge clk_i) disable iff (src_i[0])
    (|src_i) |=> rst_q);
  // R8: reset never drops in the cycle right after a source was seen
  a_r8_no_drop_after_src: assert property (@(posedge clk_i) disable iff (src_i[0])
    $fell(rst_q) |-> !$past(|src_i));
endmodule

// File: rtl/rstc_flags.sv
module rstc_flags #(
  parameter int unsigned        N    = 4,
  parameter logic [N-1:0]       INIT = '0
) (
  input  logic         clk_i,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] wr_val_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q = INIT;
  logic [N-1:0] flags_d;

  always_comb begin
    for (int i = 0; i < N; i++)
      flags_d[i] = set_i[i] | (wr_i ? wr_val_i[i] : flags_q[i]);
  end

  always_ff @(posedge clk_i) flags_q <= flags_d;

  assign flags_o = flags_q;

  // set_i[0] is the power-on request: it masks the checks below
  // R3: when power-on ends, its flag is already set
  a_r3_por_flag: assert property (@(posedge clk_i) disable iff (set_i[0])
    $fell(set_i[0]) |-> flags_q[0]);

  for (genvar g = 1; g < N; g++) begin : g_chk
    // R5 / R11: a cause pulse leaves its flag at 1, write or not
    a_r5_flag_set: assert property (@(posedge clk_i) disable iff (set_i[0])
      set_i[g] |=> flags_q[g]);
  end

  // R6: no cause and no write keeps every flag
  a_r6_hold: assert property (@(posedge clk_i) disable iff (set_i[0])
    (!wr_i && set_i == '0) |=> $stable(flags_q));
endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg
  import rstc_pkg::*;
#(
  parameter int unsigned      STRETCH_CYCLES = 16,
  parameter int unsigned      SYNC_STAGES    = 2,
  parameter logic [REG_W-1:0] POWERUP_IMAGE  = '0
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             ext_rst_n_i,
  input  logic             wdt_req_i,
  input  logic             vls_req_i,
  input  logic             lld_req_i,
  input  logic             reg_sel_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             sys_rst_o
);
  localparam int unsigned N_SRC = N_CAUSE + 1;

  logic               ext_n_sync;
  logic               ext_active;
  logic [N_CAUSE-1:0] cause_vec;
  logic [N_SRC-1:0]   stretch_src;
  logic               wr_ok;
  logic [N_CAUSE-1:0] flags;

  rstc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk_i (clk_i),
    .rst_i (por_i),
    .d_i   (ext_rst_n_i),
    .q_o   (ext_n_sync)
  );

  assign ext_active  = ~ext_n_sync;
  assign cause_vec   = {lld_req_i, vls_req_i, wdt_req_i, por_i};
  assign stretch_src = {ext_active, cause_vec};

  rstc_stretch #(.N_SRC(N_SRC), .HOLD(STRETCH_CYCLES)) u_stretch (
    .clk_i (clk_i),
    .src_i (stretch_src),
    .rst_o (sys_rst_o)
  );

  assign wr_ok = reg_sel_i & reg_we_i & ~sys_rst_o;

  rstc_flags #(.N(N_CAUSE), .INIT(image_to_flags(POWERUP_IMAGE))) u_flags (
    .clk_i    (clk_i),
    .set_i    (cause_vec),
    .wr_i     (wr_ok),
    .wr_val_i (image_to_flags(reg_wdata_i)),
    .flags_o  (flags)
  );

  assign reg_rdata_o = reg_sel_i ? flags_to_image(flags) : '0;

  always_comb begin
    // R1: reserved positions read back as 0
    a_r1_reserved_zero: assert ((reg_rdata_o & ~live_mask()) == '0);
    // R2: nothing is driven when the register is not selected
    a_r2_idle_zero: assert (reg_sel_i || reg_rdata_o == '0);
  end

  // R10: during reset, only causes can change the flags
  a_r10_write_blocked: assert property (@(posedge clk_i) disable iff (por_i)
    (sys_rst_o && cause_vec == '0) |=> $stable(flags));
  // R7: the external pin alone leaves the flags untouched
  a_r7_pin_no_flag: assert property (@(posedge clk_i) disable iff (por_i)
    (ext_active && cause_vec == '0 && !(reg_sel_i && reg_we_i)) |=> $stable(flags));
  // R11: a cause pulse beats a write on the same edge
  a_r11_cause_wins: assert property (@(posedge clk_i) disable iff (por_i)
    (wr_ok && cause_vec != '0) |=> ((flags & $past(cause_vec)) == $past(cause_vec)));
  // R3: power-on request keeps the system in reset
  a_r3_por_rst: assert property (@(posedge clk_i) disable iff (!por_i)
    por_i |=> sys_rst_o);
endmodule

// File: tb/rstc_cause_reg_bench.sv
`timescale 1ns/1ps
module rstc_cause_reg_bench;
  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       pin_n = 1'b1;
  logic       wdt = 1'b0, vls = 1'b0, lld = 1'b0;
  logic       sel = 1'b0, we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sys_rst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  sb_item_t sb_q[$];

  always #2.5 clk = ~clk;

  rstc_cause_reg #(.STRETCH_CYCLES(16), .SYNC_STAGES(2), .POWERUP_IMAGE(8'h18)) u_rstc_cause_reg (
    .clk_i       (clk),
    .por_i       (por),
    .ext_rst_n_i (pin_n),
    .wdt_req_i   (wdt),
    .vls_req_i   (vls),
    .lld_req_i   (lld),
    .reg_sel_i   (sel),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .sys_rst_o   (sys_rst)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares every plain read one step after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sel && !we) begin
        if (sb_q.size() == 0) check(1'b0, "scoreboard empty", rdata, 0);
        else begin
          sb_item_t it;
          it = sb_q.pop_front();
          check(rdata == it.exp, it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string tag);
    @(negedge clk); sel = 1'b1; we = 1'b0;
    sb_q.push_back('{e, tag});
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      1: wdt = 1'b1;
      2: vls = 1'b1;
      default: lld = 1'b1;
    endcase
    @(negedge clk); wdt = 1'b0; vls = 1'b0; lld = 1'b0;
  endtask

  task automatic measure(output int n, output int first);
    n = 0; first = 0;
    @(negedge clk);
    for (int i = 1; i <= 300; i++) begin
      @(posedge clk);
      #1;
      if (sys_rst) begin
        n++;
        if (first == 0) first = i;
      end else if (first != 0) break;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, f;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sys_rst == 1'b1, "R3 reset held during power-on", sys_rst, 1);

    // release power-on; a write in the first released cycle must be ignored (R10)
    fork
      begin @(negedge clk); por = 1'b0; end
      wr(8'h00);
      measure(n, f);
    join
    check(n == 16, "R8 power-on release length", n, 16);
    rd(8'h19, "R3 R4 R10 power-on image");

    @(negedge clk); sel = 1'b0; #1;
    check(rdata == 8'h00, "R2 unselected reads zero", rdata, 0);

    wr(8'hFF);
    rd(8'h1D, "R1 R9 write all ones");
    wr(8'h00);
    rd(8'h00, "R9 write zeros clears");

    fork pulse(1); measure(n, f); join
    check(n == 17, "R8 watchdog pulse length", n, 17);
    check(f == 1, "R5 watchdog raises reset at same edge", f, 1);
    rd(8'h04, "R5 watchdog flag");

    fork pulse(2); measure(n, f); join
    check(n == 17, "R8 supervisor pulse length", n, 17);
    rd(8'h0C, "R6 supervisor keeps watchdog");

    wr(8'h00);
    fork pulse(3); measure(n, f); join
    rd(8'h10, "R5 R6 low-level flag only");

    fork
      begin @(negedge clk); pin_n = 1'b0; repeat (5) @(negedge clk); pin_n = 1'b1; end
      measure(n, f);
    join
    check(n == 21, "R7 R8 pin reset length", n, 21);
    check(f == 3, "R7 synchronizer delay", f, 3);
    rd(8'h10, "R7 pin sets no flag");

    // same-edge write of zero and watchdog pulse
    @(negedge clk); sel = 1'b1; we = 1'b1; wdata = 8'h00; wdt = 1'b1;
    @(negedge clk); sel = 1'b0; we = 1'b0; wdt = 1'b0;
    repeat (20) @(negedge clk);
    rd(8'h04, "R11 cause beats write");

    // write inside a reset window
    fork
      pulse(2);
      begin repeat (3) @(negedge clk); wr(8'h00); end
      measure(n, f);
    join
    rd(8'h0C, "R10 write during reset ignored");

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule